// File: doc/BRIEF.md
# Raster Timing and Test Pattern Source

This block produces a complete video raster from timing parameters that software writes over an APB slave port. Each line is made of a sync interval, then a back porch, then the active pixels, then a front porch. Each frame is built from lines in the same order. The block drives horizontal sync, vertical sync and a data-valid strobe, and the polarity of each one is programmed on its own. A 24-bit RGB pixel stream runs alongside them, filled from one of eight built-in test images.

Software fills in the porch, sync and active-size fields, picks a pattern and sets the run bit. While the raster is running, software can read the line position, the pixel position within the line and the number of active pixels already sent in the current frame. Two 8-bit clock ratio values are kept as plain storage for the clock logic outside the block. A soft-reset bit stops the raster in the same way that clearing the run bit does.

Top module: `raster_pattern_gen`

## Requirements
- R1: Every APB access completes in its access phase with `pready` = 1 and `pslverr` = 0. A read of any address that is not listed in R2 or R8 returns zero.
- R2: Register fields are written in the access phase. Reads return only the field width, with the upper bits at zero. The fields are: 0x000 control (bit 0 run, bit 1 soft reset); bit 0 of 0x004 for vsync polarity, 0x008 for hsync polarity and 0x00C for data-valid polarity; 9-bit vertical sync, back porch and front porch at 0x010, 0x014 and 0x018; 11-bit active line count at 0x01C; 9-bit horizontal sync, back porch and front porch at 0x020, 0x024 and 0x028; 11-bit active pixels per line at 0x02C; 3-bit pattern select at 0x030; 8-bit clock ratio values at 0x104 and 0x108.
- R3: While run = 0 or soft reset = 1, all three position counters read zero and every sync and data-valid output sits at its inactive level, with the pixel output at zero. The counters start again from zero on the first clock after the block is allowed to run.
- R4: The pixel counter goes through 0 … HS+HB+HA+HF−1 and then wraps. Horizontal sync is asserted for counts below HS.
- R5: The line counter advances only when the pixel counter wraps and goes through 0 … VS+VB+VA+VF−1. Vertical sync is asserted for line counts below VS.
- R6: Data-valid is asserted when the pixel count is in [HS+HB, HS+HB+HA) and the line count is in [VS+VB, VS+VB+VA).
- R7: A polarity bit of 1 makes the signal active-high. A polarity bit of 0 makes it active-low, so its inactive level is 1.
- R8: The read-only register 0x200 returns the line count, 0x204 returns the pixel count and 0x208 returns the number of data-valid pixels that came before the current position in this frame. Each is 12 bits, and the data-valid count is zero at the first position of each frame.
- R9: The pixel is {R[23:16], G[15:8], B[7:0]} and is zero whenever data-valid is low. Select codes 3, 4, 5 and 6 give solid red FF0000, blue 0000FF, green 00FF00 and yellow FFFF00.
- R10: With x and y as the position inside the active area, select code 0 gives {x[7:0], y[7:0], (x+y)[7:0]}. Code 1 gives three vertical bars of red, green and blue with bar index ⌊3x/HA⌋. Code 2 gives squares of side 2^SQ_LOG, where {x[SQ_LOG], y[SQ_LOG]} = 00 white, 01 red, 10 green, 11 blue. Code 7 gives eight bars with index i = ⌊8x/HA⌋ and colour R=~i[1], G=~i[2], B=~i[0] (white, yellow, cyan, green, magenta, red, blue, black).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register file and the raster |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| hsync_o | output | 1 | Horizontal sync, with programmed polarity |
| vsync_o | output | 1 | Vertical sync, with programmed polarity |
| de_o | output | 1 | Data-valid, with programmed polarity |
| pixel_o | output | 24 | RGB pixel |

## Verification
A small raster, 14 clocks by 8 lines, is swept cycle by cycle over more than one frame for each of the eight select codes. Every output is compared with a position derived from the clock count since run was set. The solid colours show whether the select decode and the blanking are right. The ramp, bar and square images separate errors in the x/y origin, the bar-boundary arithmetic and the bit used for the squares. The polarity bits are cleared part way through the sweep, so an inverted level is told apart from a wrong interval. Soft reset and run-clear are each used to stop a running raster, and the restart is checked to show that it begins from position zero.

// File: rtl/vtpg_pkg.sv
`timescale 1ns/1ps
package vtpg_pkg;
    localparam int REG_AW  = 12;
    localparam int REG_DW  = 32;
    localparam int PORCH_W = 9;
    localparam int RES_W   = 11;
    localparam int CNT_W   = 12;
    localparam int MD_W    = 8;
    localparam int CH_W    = 8;
    localparam int PIX_W   = 3 * CH_W;
    localparam int PAT_W   = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 12'h000;
    localparam logic [REG_AW-1:0] A_POL_V = 12'h004;
    localparam logic [REG_AW-1:0] A_POL_H = 12'h008;
    localparam logic [REG_AW-1:0] A_POL_D = 12'h00C;
    localparam logic [REG_AW-1:0] A_VSW   = 12'h010;
    localparam logic [REG_AW-1:0] A_VBP   = 12'h014;
    localparam logic [REG_AW-1:0] A_VFP   = 12'h018;
    localparam logic [REG_AW-1:0] A_VACT  = 12'h01C;
    localparam logic [REG_AW-1:0] A_HSW   = 12'h020;
    localparam logic [REG_AW-1:0] A_HBP   = 12'h024;
    localparam logic [REG_AW-1:0] A_HFP   = 12'h028;
    localparam logic [REG_AW-1:0] A_HACT  = 12'h02C;
    localparam logic [REG_AW-1:0] A_PAT   = 12'h030;
    localparam logic [REG_AW-1:0] A_MVAL  = 12'h104;
    localparam logic [REG_AW-1:0] A_DVAL  = 12'h108;
    localparam logic [REG_AW-1:0] A_VCNT  = 12'h200;
    localparam logic [REG_AW-1:0] A_HCNT  = 12'h204;
    localparam logic [REG_AW-1:0] A_DECNT = 12'h208;

    typedef enum logic [PAT_W-1:0] {
        PAT_RAMP, PAT_BAR3, PAT_SQUARE, PAT_RED,
        PAT_BLUE, PAT_GREEN, PAT_YELLOW, PAT_BAR8
    } pat_e;

    typedef struct packed {
        logic               run;
        logic               srst;
        logic               pol_v;
        logic               pol_h;
        logic               pol_d;
        logic [PORCH_W-1:0] vsw;
        logic [PORCH_W-1:0] vbp;
        logic [PORCH_W-1:0] vfp;
        logic [RES_W-1:0]   vact;
        logic [PORCH_W-1:0] hsw;
        logic [PORCH_W-1:0] hbp;
        logic [PORCH_W-1:0] hfp;
        logic [RES_W-1:0]   hact;
        pat_e               pat;
        logic [MD_W-1:0]    mval;
        logic [MD_W-1:0]    dval;
    } cfg_t;
endpackage

// File: rtl/vtpg_regs.sv
`timescale 1ns/1ps
module vtpg_regs
    import vtpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [REG_AW-1:0] paddr,
    input  logic [REG_DW-1:0] pwdata,
    output logic [REG_DW-1:0] prdata,
    input  logic [CNT_W-1:0]  vcnt,
    input  logic [CNT_W-1:0]  hcnt,
    input  logic [CNT_W-1:0]  decnt,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic wr_en;
    wire  unused_wdata = ^pwdata[REG_DW-1:RES_W];

    assign wr_en = psel && penable && pwrite;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (paddr)
                A_CTRL:  begin cfg_d.run = pwdata[0]; cfg_d.srst = pwdata[1]; end
                A_POL_V: cfg_d.pol_v = pwdata[0];
                A_POL_H: cfg_d.pol_h = pwdata[0];
                A_POL_D: cfg_d.pol_d = pwdata[0];
                A_VSW:   cfg_d.vsw   = pwdata[PORCH_W-1:0];
                A_VBP:   cfg_d.vbp   = pwdata[PORCH_W-1:0];
                A_VFP:   cfg_d.vfp   = pwdata[PORCH_W-1:0];
                A_VACT:  cfg_d.vact  = pwdata[RES_W-1:0];
                A_HSW:   cfg_d.hsw   = pwdata[PORCH_W-1:0];
                A_HBP:   cfg_d.hbp   = pwdata[PORCH_W-1:0];
                A_HFP:   cfg_d.hfp   = pwdata[PORCH_W-1:0];
                A_HACT:  cfg_d.hact  = pwdata[RES_W-1:0];
                A_PAT:   cfg_d.pat   = pat_e'(pwdata[PAT_W-1:0]);
                A_MVAL:  cfg_d.mval  = pwdata[MD_W-1:0];
                A_DVAL:  cfg_d.dval  = pwdata[MD_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        prdata = '0;
        case (paddr)
            A_CTRL:  prdata[1:0]         = {cfg_q.srst, cfg_q.run};
            A_POL_V: prdata[0]           = cfg_q.pol_v;
            A_POL_H: prdata[0]           = cfg_q.pol_h;
            A_POL_D: prdata[0]           = cfg_q.pol_d;
            A_VSW:   prdata[PORCH_W-1:0] = cfg_q.vsw;
            A_VBP:   prdata[PORCH_W-1:0] = cfg_q.vbp;
            A_VFP:   prdata[PORCH_W-1:0] = cfg_q.vfp;
            A_VACT:  prdata[RES_W-1:0]   = cfg_q.vact;
            A_HSW:   prdata[PORCH_W-1:0] = cfg_q.hsw;
            A_HBP:   prdata[PORCH_W-1:0] = cfg_q.hbp;
            A_HFP:   prdata[PORCH_W-1:0] = cfg_q.hfp;
            A_HACT:  prdata[RES_W-1:0]   = cfg_q.hact;
            A_PAT:   prdata[PAT_W-1:0]   = cfg_q.pat;
            A_MVAL:  prdata[MD_W-1:0]    = cfg_q.mval;
            A_DVAL:  prdata[MD_W-1:0]    = cfg_q.dval;
            A_VCNT:  prdata[CNT_W-1:0]   = vcnt;
            A_HCNT:  prdata[CNT_W-1:0]   = hcnt;
            A_DECNT: prdata[CNT_W-1:0]   = decnt;
            default: ;
        endcase
    end

    assign cfg = cfg_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && paddr == A_CTRL) |=> (cfg_q.run == $past(pwdata[0]) && cfg_q.srst == $past(pwdata[1]))); // R2
endmodule

// File: rtl/vtpg_raster.sv
`timescale 1ns/1ps
module vtpg_raster
    import vtpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    output logic [CNT_W-1:0] hcnt,
    output logic [CNT_W-1:0] vcnt,
    output logic [CNT_W-1:0] decnt,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             de_act,
    output logic [CNT_W-1:0] xpos,
    output logic [CNT_W-1:0] ypos
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] h;
        logic [CNT_W-1:0] v;
        logic [CNT_W-1:0] de;
    } st_t;

    st_t st_d, st_q;
    logic             run, h_wrap, v_wrap, hs_act, vs_act, h_in, v_in;
    logic [SUM_W-1:0] ha_beg, ha_end, htot, va_beg, va_end, vtot;
    logic [SUM_W-1:0] h_cur, v_cur, h_nx, v_nx;

    always_comb begin
        run    = cfg.run && !cfg.srst;
        ha_beg = SUM_W'(cfg.hsw) + SUM_W'(cfg.hbp);
        ha_end = ha_beg + SUM_W'(cfg.hact);
        htot   = ha_end + SUM_W'(cfg.hfp);
        va_beg = SUM_W'(cfg.vsw) + SUM_W'(cfg.vbp);
        va_end = va_beg + SUM_W'(cfg.vact);
        vtot   = va_end + SUM_W'(cfg.vfp);
        h_cur  = SUM_W'(st_q.h);
        v_cur  = SUM_W'(st_q.v);
        h_nx   = h_cur + 1'b1;
        v_nx   = v_cur + 1'b1;
        h_wrap = h_nx >= htot;
        v_wrap = v_nx >= vtot;
        h_in   = (h_cur >= ha_beg) && (h_cur < ha_end);
        v_in   = (v_cur >= va_beg) && (v_cur < va_end);
        hs_act = run && (h_cur < SUM_W'(cfg.hsw));
        vs_act = run && (v_cur < SUM_W'(cfg.vsw));
        de_act = run && h_in && v_in;

        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else begin
            st_d.h = h_wrap ? '0 : h_nx[CNT_W-1:0];
            if (h_wrap) st_d.v = v_wrap ? '0 : v_nx[CNT_W-1:0];
            st_d.de = (h_wrap && v_wrap) ? '0 : st_q.de + CNT_W'(de_act);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hcnt    = st_q.h;
    assign vcnt    = st_q.v;
    assign decnt   = st_q.de;
    assign xpos    = CNT_W'(h_cur - ha_beg);
    assign ypos    = CNT_W'(v_cur - va_beg);
    assign hsync_o = hs_act ? cfg.pol_h : !cfg.pol_h;
    assign vsync_o = vs_act ? cfg.pol_v : !cfg.pol_v;
    assign de_o    = de_act ? cfg.pol_d : !cfg.pol_d;

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.h == '0 && st_q.v == '0 && st_q.de == '0)); // R3
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !h_wrap) |=> (st_q.h == $past(st_q.h) + 1'b1)); // R4
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !h_wrap) |=> $stable(st_q.v)); // R5
    AST_DE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_act |-> (!hs_act && !vs_act)); // R6
    AST_DECNT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (run && h_wrap && v_wrap) |=> (st_q.de == '0)); // R8
endmodule

// File: rtl/vtpg_pattern.sv
`timescale 1ns/1ps
module vtpg_pattern
    import vtpg_pkg::*;
#(
    parameter int SQ_LOG = 6
)(
    input  pat_e             pat,
    input  logic             de,
    input  logic [CNT_W-1:0] xpos,
    input  logic [CNT_W-1:0] ypos,
    input  logic [RES_W-1:0] hact,
    output logic [PIX_W-1:0] pixel
);
    localparam int PROD_W = CNT_W + 3;

    logic [2:0]        bar8;
    logic [1:0]        bar3;
    logic [1:0]        sq;
    logic [PROD_W-1:0] x8, x3, ha;
    wire               unused_y = ^ypos;

    function automatic logic [PIX_W-1:0] rgb(input logic r, input logic g, input logic b);
        return {{CH_W{r}}, {CH_W{g}}, {CH_W{b}}};
    endfunction

    always_comb begin
        x8 = {xpos, 3'b000};
        x3 = PROD_W'(xpos) + PROD_W'({xpos, 1'b0});
        ha = PROD_W'(hact);
        bar8 = '0;
        for (int k = 1; k < 8; k++) begin
            if (x8 >= PROD_W'(k) * ha) bar8 = bar8 + 3'd1;
        end
        if (x3 >= {ha[PROD_W-2:0], 1'b0}) bar3 = 2'd2;
        else if (x3 >= ha)                 bar3 = 2'd1;
        else                               bar3 = 2'd0;
        sq = {xpos[SQ_LOG], ypos[SQ_LOG]};

        case (pat)
            PAT_RAMP:   pixel = {xpos[CH_W-1:0], ypos[CH_W-1:0], xpos[CH_W-1:0] + ypos[CH_W-1:0]};
            PAT_BAR3:   pixel = rgb(bar3 == 2'd0, bar3 == 2'd1, bar3 == 2'd2);
            PAT_SQUARE: pixel = rgb(sq == 2'b00 || sq == 2'b01, sq == 2'b00 || sq == 2'b10,
                                    sq == 2'b00 || sq == 2'b11);
            PAT_RED:    pixel = rgb(1'b1, 1'b0, 1'b0);
            PAT_BLUE:   pixel = rgb(1'b0, 1'b0, 1'b1);
            PAT_GREEN:  pixel = rgb(1'b0, 1'b1, 1'b0);
            PAT_YELLOW: pixel = rgb(1'b1, 1'b1, 1'b0);
            default:    pixel = rgb(!bar8[1], !bar8[2], !bar8[0]);
        endcase
        if (!de) pixel = '0;
    end
endmodule

// File: rtl/raster_pattern_gen.sv
`timescale 1ns/1ps
module raster_pattern_gen
    import vtpg_pkg::*;
#(
    parameter int SQ_LOG = 6
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    output logic        pready,
    output logic        pslverr,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic [23:0] pixel_o
);
    cfg_t             cfg;
    logic [CNT_W-1:0] hcnt, vcnt, decnt, xpos, ypos;
    logic             de_act;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    vtpg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .vcnt(vcnt), .hcnt(hcnt), .decnt(decnt), .cfg(cfg)
    );

    vtpg_raster u_raster (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .hcnt(hcnt), .vcnt(vcnt), .decnt(decnt),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .de_act(de_act),
        .xpos(xpos), .ypos(ypos)
    );

    vtpg_pattern #(.SQ_LOG(SQ_LOG)) u_pattern (
        .pat(cfg.pat), .de(de_act), .xpos(xpos), .ypos(ypos),
        .hact(cfg.hact), .pixel(pixel_o)
    );
endmodule

// File: tb/raster_pattern_gen_test.sv
`timescale 1ns/1ps
module raster_pattern_gen_test;
    localparam int HSW = 2, HBP = 3, HACT = 8, HFP = 1;
    localparam int VSW = 1, VBP = 2, VACT = 4, VFP = 1;
    localparam int HTOT = HSW + HBP + HACT + HFP;
    localparam int VTOT = VSW + VBP + VACT + VFP;
    localparam int SQL  = 1;

    logic        clk = 0, rst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic        pready, pslverr, hs, vs, de;
    logic [23:0] pix;

    int cyc = 0, e0 = 0, last_edge = 0;
    int n_cmp = 0, n_bad = 0;
    int cur_pat = 0;
    bit running = 0, ph = 0, pv = 0, pd = 0, done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    raster_pattern_gen #(.SQ_LOG(SQL)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .pixel_o(pix)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(posedge clk);
        last_edge = cyc;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output int n);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1;
        d = prdata;
        n = cyc - e0 - 1;
        check("R1 pready", {31'd0, pready}, 32'd1);
        check("R1 pslverr", {31'd0, pslverr}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    function automatic logic [23:0] rgb(input bit r, input bit g, input bit b);
        return {{8{r}}, {8{g}}, {8{b}}};
    endfunction

    function automatic logic [23:0] pix_exp(input int pat, input int x, input int y);
        int i;
        case (pat)
            0: return {x[7:0], y[7:0], 8'((x + y) % 256)};
            1: begin i = (3 * x) / HACT; return rgb(i == 0, i == 1, i == 2); end
            2: begin
                i = 2 * ((x >> SQL) % 2) + ((y >> SQL) % 2);
                return (i == 0) ? 24'hFFFFFF : (i == 1) ? 24'hFF0000 : (i == 2) ? 24'h00FF00 : 24'h0000FF;
            end
            3: return 24'hFF0000;
            4: return 24'h0000FF;
            5: return 24'h00FF00;
            6: return 24'hFFFF00;
            default: begin i = (8 * x) / HACT; return rgb(i[1] == 0, i[2] == 0, i[0] == 0); end
        endcase
    endfunction

    function automatic bit is_act(input int h, input int v);
        return (h >= HSW + HBP) && (h < HSW + HBP + HACT) && (v >= VSW + VBP) && (v < VSW + VBP + VACT);
    endfunction

    function automatic int decnt_exp(input int n);
        int p = n % (HTOT * VTOT);
        int c = 0;
        for (int q = 0; q < p; q++) if (is_act(q % HTOT, q / HTOT)) c++;
        return c % 4096;
    endfunction

    task automatic sweep(input int ncyc);
        for (int k = 0; k < ncyc; k++) begin
            int n, h, v;
            bit ehs, evs, ede;
            logic [23:0] ep;
            @(negedge clk);
            n = cyc - e0 - 1;
            h = n % HTOT;
            v = (n / HTOT) % VTOT;
            ehs = running && (h < HSW);
            evs = running && (v < VSW);
            ede = running && is_act(h, v);
            ep  = ede ? pix_exp(cur_pat, h - HSW - HBP, v - VSW - VBP) : 24'd0;
            check("R4 R7 hsync", {31'd0, hs}, {31'd0, ehs ? ph : !ph});
            check("R5 R7 vsync", {31'd0, vs}, {31'd0, evs ? pv : !pv});
            check("R6 R7 de", {31'd0, de}, {31'd0, ede ? pd : !pd});
            check((cur_pat >= 3 && cur_pat <= 6) ? "R9 pixel" : "R10 pixel", {8'd0, pix}, {8'd0, ep});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        // R3: reset state, polarities zero so inactive level is high
        check("R3 reset hsync", {31'd0, hs}, 32'd1);
        check("R3 reset vsync", {31'd0, vs}, 32'd1);
        check("R3 reset de", {31'd0, de}, 32'd1);
        check("R3 reset pixel", {8'd0, pix}, 32'd0);
        rst_n = 1;
        rd(12'h000, d, n); check("R3 ctrl after reset", d, 32'd0);
        rd(12'h204, d, n); check("R3 hcnt after reset", d, 32'd0);

        // R2: field masking and storage
        wr(12'h028, 32'hFFFF_FFFF); rd(12'h028, d, n); check("R2 hfp mask", d, 32'h1FF);
        wr(12'h02C, 32'hFFFF_FFFF); rd(12'h02C, d, n); check("R2 hact mask", d, 32'h7FF);
        wr(12'h030, 32'hFFFF_FFFF); rd(12'h030, d, n); check("R2 pattern mask", d, 32'h7);
        wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, d, n); check("R2 de polarity", d, 32'h1);
        wr(12'h104, 32'h1234_56A5); rd(12'h104, d, n); check("R2 ratio M", d, 32'hA5);
        wr(12'h108, 32'h0000_0B3C); rd(12'h108, d, n); check("R2 ratio D", d, 32'h3C);
        rd(12'h104, d, n); check("R2 ratio M kept", d, 32'hA5);
        // R1: unmapped addresses read zero
        rd(12'h034, d, n); check("R1 unmapped 034", d, 32'd0);
        rd(12'h0FC, d, n); check("R1 unmapped 0FC", d, 32'd0);
        rd(12'h20C, d, n); check("R1 unmapped 20C", d, 32'd0);

        wr(12'h010, VSW); wr(12'h014, VBP); wr(12'h018, VFP); wr(12'h01C, VACT);
        wr(12'h020, HSW); wr(12'h024, HBP); wr(12'h028, HFP); wr(12'h02C, HACT);
        rd(12'h020, d, n); check("R2 hsync width", d, HSW);
        wr(12'h004, 1); wr(12'h008, 1); wr(12'h00C, 1);
        pv = 1; ph = 1; pd = 1;
        wr(12'h030, 0); cur_pat = 0;
        wr(12'h000, 1); e0 = last_edge; running = 1;

        for (int p = 0; p < 8; p++) begin
            if (p == 4) begin
                // R7: switch every signal to active-low mid-run
                wr(12'h004, 0); pv = 0;
                wr(12'h008, 0); ph = 0;
                wr(12'h00C, 0); pd = 0;
            end
            wr(12'h030, p); cur_pat = p;
            sweep(120);
            if (p == 2) begin
                for (int r = 0; r < 5; r++) begin
                    rd(12'h200, d, n); check("R8 line count", d, (n / HTOT) % VTOT);
                    rd(12'h204, d, n); check("R8 pixel count", d, n % HTOT);
                    rd(12'h208, d, n); check("R8 valid count", d, decnt_exp(n));
                    sweep(17);
                end
            end
        end

        // R3: soft reset stops the raster
        wr(12'h000, 3); running = 0;
        sweep(20);
        rd(12'h200, d, n); check("R3 line count in soft reset", d, 32'd0);
        rd(12'h204, d, n); check("R3 pixel count in soft reset", d, 32'd0);
        rd(12'h208, d, n); check("R3 valid count in soft reset", d, 32'd0);
        wr(12'h000, 1); e0 = last_edge; running = 1;
        sweep(40);
        wr(12'h000, 0); running = 0;
        sweep(10);
        rd(12'h204, d, n); check("R3 pixel count after stop", d, 32'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule